// File: doc/BRIEF.md
# Threshold-Compare Packet Arrival Controller

This block tells a traffic source, one cycle at a time, when a new packet should be created. Each cycle in which generation is active, an 8-bit pseudo-random value from a maximal-length linear feedback shift register is compared against a programmable threshold. When the threshold is greater than or equal to the random value, a packet arrives. A larger threshold therefore gives a higher arrival probability, and the gaps between arrivals follow a geometric distribution.

A mode input chooses how arrivals are spaced. In head-to-head mode the generator runs on its own and a saturating pending count records packets created but not yet sent. In tail-to-head mode the generator pauses after each arrival. It resumes only after the injection logic reports that the packet has left, so at most one packet is outstanding and the random sequence is frozen while it waits. In both modes the packet request output is high whenever the pending count is non-zero. The packet-sent pulse from the injection logic lowers the count.

Top module: `pkt_arrival_ctrl`

## Requirements
- R1: After reset `pend_cnt_o` is 0, `pkt_req_o` is 0, the threshold is 0 and the random register holds the seed 0x01.
- R2: In a cycle where generation is active, an arrival occurs exactly when threshold >= random value. Threshold 0 never produces an arrival, because the random value is never 0. Threshold 255 produces an arrival in every active cycle.
- R3: The random register takes the next value {q[6:0], q[7]^q[5]^q[4]^q[3]} in every active cycle and holds its value otherwise. It never becomes 0.
- R4: A threshold write (`thr_we_i`=1) loads `thr_wdata_i` on the clock edge only when `gen_en_i`=0. While `gen_en_i`=1 the write is ignored.
- R5: On each clock edge the pending count rises by 1 for an arrival and falls by 1 for `pkt_sent_i`=1. An arrival and a send in the same cycle leave the count unchanged.
- R6: The count saturates at 15: an arrival without a send at 15 leaves it at 15. A send without an arrival at 0 leaves it at 0.
- R7: With `mode_i`=1 (tail-to-head), generation is active only when `gen_en_i`=1 and the count is 0. After an arrival the count is 1, and it stays 1 with no further arrivals and a frozen random register until `pkt_sent_i` is seen.
- R8: With `mode_i`=0 (head-to-head), generation is active whenever `gen_en_i`=1, whatever the count.
- R9: `pkt_req_o` is 1 exactly when `pend_cnt_o` is non-zero. With `gen_en_i`=0 there are no arrivals and sends still lower the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en_i | input | 1 | Arrival generation enable; also locks the threshold |
| mode_i | input | 1 | 0 = head-to-head, 1 = tail-to-head |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_wdata_i | input | 8 | Threshold write value |
| pkt_sent_i | input | 1 | Pulse from injection logic: one packet has left |
| pkt_req_o | output | 1 | A packet is waiting to be created/sent |
| pend_cnt_o | output | 4 | Pending packet count |

## Verification
The bench drives the count into both saturation limits. A counter that wraps at the top would fall to 0, and one that underflows would jump to 15. It issues arrivals and sends in the same cycle, where a design that gives either one priority would drift by one. In tail-to-head mode it holds a packet outstanding for many cycles. A design that does not freeze the random register or the generator there would show extra arrivals or a shifted arrival pattern after the release. Writes made while generation is enabled must leave the arrival rate unchanged. A random phase mixes modes, rates and sends so that any error in the feedback taps changes the predicted count sequence.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic {
        MODE_HEAD_HEAD = 1'b0,
        MODE_TAIL_HEAD = 1'b1
    } arr_mode_e;

    // Feedback tap mask for a maximal-length shift register of the given width.
    function automatic logic [31:0] lfsr_taps(input int unsigned w);
        case (w)
            4:       lfsr_taps = 32'h0000_000C;
            8:       lfsr_taps = 32'h0000_00B8;
            12:      lfsr_taps = 32'h0000_0E08;
            16:      lfsr_taps = 32'h0000_B400;
            default: lfsr_taps = 32'h0000_00B8;
        endcase
    endfunction

endpackage

// File: rtl/pac_lfsr.sv
module pac_lfsr #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] val_o
);
    import pac_pkg::*;

    localparam logic [31:0]  TAPS_FULL = lfsr_taps(W);
    localparam logic [W-1:0] TAPS      = TAPS_FULL[W-1:0];

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.sr & TAPS);
        if (adv_i) begin
            st_d.sr = {st_q.sr[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.sr;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        val_o != '0); // R3
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(val_o)); // R3
    AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> !$stable(val_o)); // R3

endmodule

// File: rtl/pac_thresh.sv
module pac_thresh #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] rnd_i,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] thr;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && !lock_i) begin
            st_d.thr = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = (st_q.thr >= rnd_i);

    AST_THR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(st_q.thr)); // R4

endmodule

// File: rtl/pac_pend.sv
module pac_pend #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i && !dec_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec_i && !inc_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_PEND_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX) && inc_i && !dec_i |=> cnt_o == CNT_MAX); // R6
    AST_PEND_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0) && dec_i && !inc_i |=> cnt_o == '0); // R6
    AST_PEND_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && dec_i |=> $stable(cnt_o)); // R5

endmodule

// File: rtl/pkt_arrival_ctrl.sv
module pkt_arrival_ctrl #(
    parameter int unsigned RND_W  = 8,
    parameter int unsigned PEND_W = 4,
    parameter logic [RND_W-1:0] RND_SEED = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en_i,
    input  logic              mode_i,
    input  logic              thr_we_i,
    input  logic [RND_W-1:0]  thr_wdata_i,
    input  logic              pkt_sent_i,
    output logic              pkt_req_o,
    output logic [PEND_W-1:0] pend_cnt_o
);
    import pac_pkg::*;

    arr_mode_e        mode;
    logic             gen_active;
    logic             arrival;
    logic             thr_hit;
    logic [RND_W-1:0] rnd_val;

    always_comb begin
        mode       = arr_mode_e'(mode_i);
        gen_active = gen_en_i &&
                     ((mode == MODE_HEAD_HEAD) || (pend_cnt_o == '0));
        arrival    = gen_active && thr_hit;
    end

    pac_lfsr #(
        .W    (RND_W),
        .SEED (RND_SEED)
    ) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (gen_active),
        .val_o (rnd_val)
    );

    pac_thresh #(
        .W (RND_W)
    ) thresh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (gen_en_i),
        .we_i    (thr_we_i),
        .wdata_i (thr_wdata_i),
        .rnd_i   (rnd_val),
        .hit_o   (thr_hit)
    );

    pac_pend #(
        .CW (PEND_W)
    ) pend_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (arrival),
        .dec_i (pkt_sent_i),
        .cnt_o (pend_cnt_o)
    );

    assign pkt_req_o = (pend_cnt_o != '0);

    AST_T2H_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TAIL_HEAD) && (pend_cnt_o != '0) |=> $stable(rnd_val)); // R7
    AST_T2H_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TAIL_HEAD) && (pend_cnt_o <= 1) |=> pend_cnt_o <= 1); // R7
    AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en_i |=> pend_cnt_o <= $past(pend_cnt_o)); // R9

endmodule

// File: tb/pkt_arrival_ctrl_tb.sv
module pkt_arrival_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic       mode = 1'b0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wd = 8'h00;
    logic       sent = 1'b0;
    logic       req;
    logic [3:0] pend;

    int checks = 0;
    int errors = 0;

    // bench-side expected state
    logic [7:0] m_rnd;
    logic [7:0] m_thr;
    int         m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_arrival_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_en_i    (gen_en),
        .mode_i      (mode),
        .thr_we_i    (thr_we),
        .thr_wdata_i (thr_wd),
        .pkt_sent_i  (sent),
        .pkt_req_o   (req),
        .pend_cnt_o  (pend)
    );

    function automatic logic [7:0] next_rnd(input logic [7:0] q);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction

    function automatic int next_pend(input int p, input bit inc, input bit dec);
        if (inc && !dec) return (p == MAXC) ? MAXC : p + 1;
        if (dec && !inc) return (p == 0) ? 0 : p - 1;
        return p;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at negedge, update model at posedge, compare at next negedge.
    task automatic cyc(input bit g, input bit md, input bit we, input logic [7:0] wd,
                       input bit s, input string tag);
        bit act, arr;
        gen_en = g; mode = md; thr_we = we; thr_wd = wd; sent = s;
        @(posedge clk);
        act = g && (!md || m_pend == 0);
        arr = act && (m_thr >= m_rnd);
        m_pend = next_pend(m_pend, arr, s);
        if (act) m_rnd = next_rnd(m_rnd);
        if (we && !g) m_thr = wd;
        @(negedge clk);
        check({tag, " count"}, int'(pend), m_pend);
        check("R9 req", int'(req), (m_pend != 0) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        m_rnd = 8'h01; m_thr = 8'h00; m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset count", int'(pend), 0);
        check("R1 reset req", int'(req), 0);

        // R2 threshold 0: no arrivals ever
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, 8'h00, 0, "R2 thr0");
        check("R2 thr0 final", int'(pend), 0);

        // R4 write while enabled is ignored: rate stays zero
        cyc(1, 0, 1, 8'hFF, 0, "R4 locked write");
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 8'h00, 0, "R4 after locked write");
        check("R4 ignored write", int'(pend), 0);

        // R4 write while disabled, threshold 255
        cyc(0, 0, 1, 8'hFF, 0, "R4 write");
        // R2/R6 every cycle arrives, saturates at 15
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 8'h00, 0, "R6 climb");
        check("R6 saturate top", int'(pend), 15);

        // R5 arrival and send together: unchanged
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 8'h00, 1, "R5 balanced");
        check("R5 balanced", int'(pend), 15);

        // R9 disabled, sends drain; R6 floor
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 8'h00, 1, "R9 drain");
        check("R6 floor", int'(pend), 0);

        // R7 tail-to-head suspension with threshold 255
        cyc(1, 1, 0, 8'h00, 0, "R7 first arrival");
        check("R7 one outstanding", int'(pend), 1);
        for (int i = 0; i < 30; i++) cyc(1, 1, 0, 8'h00, 0, "R7 hold");
        check("R7 still one", int'(pend), 1);
        cyc(1, 1, 0, 8'h00, 1, "R7 release");
        check("R7 released", int'(pend), 0);
        cyc(1, 1, 0, 8'h00, 0, "R7 resume");
        check("R7 resumed", int'(pend), 1);
        cyc(1, 1, 0, 8'h00, 1, "R7 release2");

        // R8 head-to-head with mid threshold, R3 sequence via pattern
        cyc(0, 0, 1, 8'h60, 0, "R4 write mid");
        for (int i = 0; i < 200; i++) cyc(1, 0, 0, 8'h00, (i % 3) == 0, "R8 R3 mid rate");

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            bit g, md, we, s;
            g  = ($urandom_range(0, 9) != 0);
            md = (i / 500) % 2 == 1;
            we = ($urandom_range(0, 3) == 0);
            s  = ($urandom_range(0, 2) == 0);
            cyc(g, md, we, 8'($urandom_range(0, 255)), s, "R3 R5 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule